// File: doc/BRIEF.md
# VLIW Flow Control Unit

This block is the single-slot control engine of a small very-long-instruction-word core. It owns the program counter and the run state of the core, which is one of running, paused or stopped. Each cycle it takes one decoded control operation, plus the operand words already read from scratch memory and an immediate field, and works out the next program counter, the new run state and an optional write back to scratch.

The operation set covers a scalar choice between two words, an eight-lane choice made per lane, an add of an immediate, absolute, conditional, PC-relative and register-indirect jumps, halt and pause. The counter moves forward by one before the slot takes effect, so relative targets are measured from the next instruction. All outcomes (new PC, new state, the scratch write) are committed together at the clock edge, after every input of the cycle has been sampled. The scratch write is presented on the output port in the cycle after the operation as a base address, a lane mask and the lane data.

Top module: `vfc_flow_unit`

## Requirements
- R1: A synchronous reset sets the PC to 0, the state to running (code 0) and the write-valid output low.
- R2: While running with PC below the program length, an operation that is not a taken jump moves the PC to PC+1 at the clock edge.
- R3: Scalar select (op 1) writes, one cycle later, lane 0 of the data bus with operand a when the condition word is nonzero and with operand b when it is zero; mask is 8'h01 and the address is the destination field.
- R4: Vector select (op 2) picks a or b separately in each of the lanes by that lane's own condition word; lane i occupies data bits [32i+31:32i] and the mask is all ones.
- R5: Add-immediate (op 3) writes operand a plus the immediate, wrapped modulo 2^32, into lane 0 with mask 8'h01.
- R6: Absolute jump (op 4) loads the PC from the low bits of the immediate; conditional jump (op 5) does so only when the condition word is nonzero, else the PC becomes PC+1.
- R7: Relative jump (op 6), when the condition word is nonzero, sets the PC to PC+1 plus the immediate taken as a signed offset, wrapping at the PC width.
- R8: Indirect jump (op 7) loads the PC from the low bits of operand a.
- R9: Halt (op 8) moves the core to stopped (code 2); a stopped core keeps its PC, issues no writes and ignores all operations until reset.
- R10: Pause (op 9) moves the core to paused (code 1) with PC+1 only when pause-enable is high, otherwise it acts like a no-op; a paused core ignores operations and returns to running on the run command.
- R11: A running core whose PC is at or beyond the program length becomes stopped at the next edge without executing the operation: no write and no PC change.
- R12: Opcode 0 and the unused codes 10 to 15 change nothing but advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_cmd | input | 1 | Resume a paused core |
| pause_en | input | 1 | Allows pause to take effect |
| prog_len | input | PCW+1 | Number of instructions in the program |
| op | input | 4 | Decoded control opcode |
| dst | input | AW | Scratch destination base address |
| imm | input | 32 | Immediate, jump target or offset |
| cond_w | input | 32 | Scalar condition word |
| opa_w | input | 32 | Scalar operand a |
| opb_w | input | 32 | Scalar operand b |
| vcond | input | LANES*32 | Per-lane condition words |
| va | input | LANES*32 | Per-lane operand a |
| vb | input | LANES*32 | Per-lane operand b |
| pc | output | PCW | Program counter |
| core_st | output | 2 | Run state: 0 running, 1 paused, 2 stopped |
| wr_valid | output | 1 | Scratch write request |
| wr_addr | output | AW | Scratch write base address |
| wr_mask | output | LANES | Lanes written |
| wr_data | output | LANES*32 | Write data, lane 0 in the low word |

## Verification
On every cycle the assertions hold the state machine to its rules: reset values, the stopped state never leaving, a frozen PC outside the running state, writes only after an executed operation, end-of-program stopping without a write, halt stopping the core, a disabled pause leaving it running and the write mask taking only its two legal shapes. The values themselves (the lane-by-lane choice, the wrapped sum, each jump target and relative offsets counted from PC+1) are shown only by the bench's scenarios, which compare every result against a separate model of the operation set under random and directed inputs.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_SEL   = 4'd1,
    OP_VSEL  = 4'd2,
    OP_ADDI  = 4'd3,
    OP_JMP   = 4'd4,
    OP_CJMP  = 4'd5,
    OP_CJREL = 4'd6,
    OP_JIND  = 4'd7,
    OP_HALT  = 4'd8,
    OP_PAUSE = 4'd9
  } flow_op_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PAUSE = 2'd1,
    ST_STOP  = 2'd2
  } core_st_e;

  function automatic word_t pick_word(word_t c, word_t a, word_t b);
    return (c != '0) ? a : b;
  endfunction

  function automatic word_t add_wrap(word_t a, word_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/vfc_lane_sel.sv
module vfc_lane_sel
  import vfc_pkg::*;
(
  input  word_t c,
  input  word_t a,
  input  word_t b,
  output word_t y
);
  assign y = pick_word(c, a, b);
endmodule

// File: rtl/vfc_datapath.sv
module vfc_datapath
  import vfc_pkg::*;
#(
  parameter int LANES = 8
) (
  input  flow_op_e                 op_e,
  input  word_t                    cond_w,
  input  word_t                    opa_w,
  input  word_t                    opb_w,
  input  word_t                    imm,
  input  logic [LANES*WORD_W-1:0]  vcond,
  input  logic [LANES*WORD_W-1:0]  va,
  input  logic [LANES*WORD_W-1:0]  vb,
  output logic [LANES*WORD_W-1:0]  res,
  output logic [LANES-1:0]         mask,
  output logic                     wr
);
  logic [LANES*WORD_W-1:0] vsel_res;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    vfc_lane_sel u_lane (
      .c (vcond[i*WORD_W +: WORD_W]),
      .a (va[i*WORD_W +: WORD_W]),
      .b (vb[i*WORD_W +: WORD_W]),
      .y (vsel_res[i*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    res  = '0;
    mask = '0;
    wr   = 1'b0;
    unique case (op_e)
      OP_SEL: begin
        res[WORD_W-1:0] = pick_word(cond_w, opa_w, opb_w);
        mask            = LANES'(1);
        wr              = 1'b1;
      end
      OP_VSEL: begin
        res  = vsel_res;
        mask = '1;
        wr   = 1'b1;
      end
      OP_ADDI: begin
        res[WORD_W-1:0] = add_wrap(opa_w, imm);
        mask            = LANES'(1);
        wr              = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vfc_next_pc.sv
module vfc_next_pc
  import vfc_pkg::*;
#(
  parameter int PCW = 10
) (
  input  flow_op_e         op_e,
  input  logic [PCW-1:0]   pc,
  input  word_t            cond_w,
  input  logic [PCW-1:0]   tgt_imm,
  input  logic [PCW-1:0]   tgt_reg,
  output logic [PCW-1:0]   pc_inc,
  output logic [PCW-1:0]   pc_next
);
  logic cond_true;
  assign cond_true = (cond_w != '0);
  assign pc_inc    = pc + PCW'(1);

  always_comb begin
    pc_next = pc_inc;
    unique case (op_e)
      OP_JMP:   pc_next = tgt_imm;
      OP_CJMP:  if (cond_true) pc_next = tgt_imm;
      OP_CJREL: if (cond_true) pc_next = pc_inc + tgt_imm;
      OP_JIND:  pc_next = tgt_reg;
      default: ;
    endcase
  end
endmodule

// File: rtl/vfc_run_state.sv
module vfc_run_state
  import vfc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     run_cmd,
  input  logic     halt_req,
  input  logic     pause_req,
  input  logic     end_hit,
  output core_st_e st
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_RUN;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (end_hit || halt_req) st <= ST_STOP;
          else if (pause_req)      st <= ST_PAUSE;
        end
        ST_PAUSE: if (run_cmd) st <= ST_RUN;
        default:  st <= ST_STOP;
      endcase
    end
  end

  p_stop_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    st == ST_STOP |=> st == ST_STOP);

  p_resume_r10: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAUSE && run_cmd) |=> st == ST_RUN);
endmodule

// File: rtl/vfc_flow_unit.sv
module vfc_flow_unit
  import vfc_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PCW   = 10,
  parameter int AW    = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run_cmd,
  input  logic                    pause_en,
  input  logic [PCW:0]            prog_len,
  input  logic [3:0]              op,
  input  logic [AW-1:0]           dst,
  input  logic [31:0]             imm,
  input  logic [31:0]             cond_w,
  input  logic [31:0]             opa_w,
  input  logic [31:0]             opb_w,
  input  logic [LANES*32-1:0]     vcond,
  input  logic [LANES*32-1:0]     va,
  input  logic [LANES*32-1:0]     vb,
  output logic [PCW-1:0]          pc,
  output logic [1:0]              core_st,
  output logic                    wr_valid,
  output logic [AW-1:0]           wr_addr,
  output logic [LANES-1:0]        wr_mask,
  output logic [LANES*32-1:0]     wr_data
);
  localparam int DATA_W = LANES * WORD_W;

  flow_op_e           op_e;
  core_st_e           st;
  logic               running, end_hit, exec, halt_req, pause_req;
  logic [PCW-1:0]     pc_inc, pc_next;
  logic [DATA_W-1:0]  res;
  logic [LANES-1:0]   res_mask;
  logic               res_wr;

  assign op_e      = flow_op_e'(op);
  assign running   = (st == ST_RUN);
  assign end_hit   = running && ({1'b0, pc} >= prog_len);
  assign exec      = running && !end_hit;
  assign halt_req  = exec && (op_e == OP_HALT);
  assign pause_req = exec && (op_e == OP_PAUSE) && pause_en;
  assign core_st   = st;

  vfc_datapath #(.LANES(LANES)) u_dp (
    .op_e   (op_e),
    .cond_w (cond_w),
    .opa_w  (opa_w),
    .opb_w  (opb_w),
    .imm    (imm),
    .vcond  (vcond),
    .va     (va),
    .vb     (vb),
    .res    (res),
    .mask   (res_mask),
    .wr     (res_wr)
  );

  vfc_next_pc #(.PCW(PCW)) u_npc (
    .op_e    (op_e),
    .pc      (pc),
    .cond_w  (cond_w),
    .tgt_imm (imm[PCW-1:0]),
    .tgt_reg (opa_w[PCW-1:0]),
    .pc_inc  (pc_inc),
    .pc_next (pc_next)
  );

  vfc_run_state u_st (
    .clk       (clk),
    .rst       (rst),
    .run_cmd   (run_cmd),
    .halt_req  (halt_req),
    .pause_req (pause_req),
    .end_hit   (end_hit),
    .st        (st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_mask  <= '0;
      wr_data  <= '0;
    end else begin
      if (exec) pc <= pc_next;
      wr_valid <= exec && res_wr;
      if (exec && res_wr) begin
        wr_addr <= dst;
        wr_mask <= res_mask;
        wr_data <= res;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && core_st == 2'd0 && !wr_valid));

  p_pc_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(pc));

  p_write_needs_exec_r11: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(exec));

  p_end_stops_r11: assert property (@(posedge clk) disable iff (rst)
    end_hit |=> (st == ST_STOP && !wr_valid && $stable(pc)));

  p_halt_stops_r9: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> st == ST_STOP);

  p_pause_off_r10: assert property (@(posedge clk) disable iff (rst)
    (exec && op_e == OP_PAUSE && !pause_en) |=> st == ST_RUN);

  p_mask_shape_r4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ((wr_mask == LANES'(1)) || (&wr_mask)));

  p_plain_step_r2: assert property (@(posedge clk) disable iff (rst)
    (exec && op_e inside {OP_NOP, OP_SEL, OP_VSEL, OP_ADDI}) |=> pc == $past(pc) + PCW'(1));
endmodule

// File: tb/vfc_flow_unit_tb_top.sv
`timescale 1ns/1ps
module vfc_flow_unit_tb_top;
  localparam int LANES = 8;
  localparam int PCW   = 10;
  localparam int AW    = 11;
  localparam int DW    = LANES * 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              run_cmd = 1'b0;
  logic              pause_en = 1'b0;
  logic [PCW:0]      prog_len = 11'd40;
  logic [3:0]        op = 4'd0;
  logic [AW-1:0]     dst = '0;
  logic [31:0]       imm = '0, cond_w = '0, opa_w = '0, opb_w = '0;
  logic [DW-1:0]     vcond = '0, va = '0, vb = '0;
  logic [PCW-1:0]    pc;
  logic [1:0]        core_st;
  logic              wr_valid;
  logic [AW-1:0]     wr_addr;
  logic [LANES-1:0]  wr_mask;
  logic [DW-1:0]     wr_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // model state
  logic [PCW-1:0]    m_pc;
  logic [1:0]        m_st;

  always #10 clk = ~clk;

  vfc_flow_unit #(.LANES(LANES), .PCW(PCW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .run_cmd(run_cmd), .pause_en(pause_en),
    .prog_len(prog_len), .op(op), .dst(dst), .imm(imm), .cond_w(cond_w),
    .opa_w(opa_w), .opb_w(opb_w), .vcond(vcond), .va(va), .vb(vb),
    .pc(pc), .core_st(core_st), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_mask(wr_mask), .wr_data(wr_data)
  );

  function automatic logic [31:0] b_choose(logic [31:0] c, logic [31:0] a, logic [31:0] b);
    if (c == 32'd0) return b;
    return a;
  endfunction

  function automatic logic [31:0] b_sum(logic [31:0] a, logic [31:0] b);
    logic [32:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[31:0];
  endfunction

  function automatic logic [31:0] rnd_word();
    if ($urandom_range(1, 0) == 0) return 32'd0;
    return $urandom;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op  = 4'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst  = 1'b0;
    m_pc = '0;
    m_st = 2'd0;
    chk(pc == '0, "R1", "pc", DW'(pc), '0);
    chk(core_st == 2'd0, "R1", "state", DW'(core_st), '0);
    chk(!wr_valid, "R1", "wr_valid", DW'(wr_valid), '0);
  endtask

  // Inputs already set at a falling edge; model, clock, compare.
  task automatic step();
    logic             e_wv;
    logic [LANES-1:0] e_mask;
    logic [DW-1:0]    e_data;
    logic [AW-1:0]    e_addr;
    logic [PCW-1:0]   pci, nxt;
    string            tag;
    e_wv = 1'b0; e_mask = '0; e_data = '0; e_addr = dst; tag = "R12";
    if (m_st == 2'd0) begin
      if ({1'b0, m_pc} >= prog_len) begin
        m_st = 2'd2; tag = "R11";
      end else begin
        pci = m_pc + PCW'(1);
        nxt = pci;
        case (op)
          4'd1: begin tag = "R3"; e_wv = 1'b1; e_mask = 8'h01;
                  e_data[31:0] = b_choose(cond_w, opa_w, opb_w); end
          4'd2: begin tag = "R4"; e_wv = 1'b1; e_mask = 8'hFF;
                  for (int i = 0; i < LANES; i++)
                    e_data[i*32 +: 32] = b_choose(vcond[i*32 +: 32], va[i*32 +: 32], vb[i*32 +: 32]);
                end
          4'd3: begin tag = "R5"; e_wv = 1'b1; e_mask = 8'h01;
                  e_data[31:0] = b_sum(opa_w, imm); end
          4'd4: begin tag = "R6"; nxt = imm[PCW-1:0]; end
          4'd5: begin tag = "R6"; if (cond_w != 0) nxt = imm[PCW-1:0]; end
          4'd6: begin tag = "R7"; if (cond_w != 0) nxt = pci + imm[PCW-1:0]; end
          4'd7: begin tag = "R8"; nxt = opa_w[PCW-1:0]; end
          4'd8: begin tag = "R9"; m_st = 2'd2; end
          4'd9: begin tag = "R10"; if (pause_en) m_st = 2'd1; end
          default: tag = (op == 4'd0) ? "R2" : "R12";
        endcase
        m_pc = nxt;
      end
    end else if (m_st == 2'd1) begin
      tag = "R10";
      if (run_cmd) m_st = 2'd0;
    end else begin
      tag = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    chk(pc == m_pc, tag, "pc", DW'(pc), DW'(m_pc));
    chk(core_st == m_st, tag, "state", DW'(core_st), DW'(m_st));
    chk(wr_valid == e_wv, tag, "wr_valid", DW'(wr_valid), DW'(e_wv));
    if (e_wv && wr_valid) begin
      chk(wr_addr == e_addr, tag, "wr_addr", DW'(wr_addr), DW'(e_addr));
      chk(wr_mask == e_mask, tag, "wr_mask", DW'(wr_mask), DW'(e_mask));
      chk((wr_data & {{(DW-32){e_mask[LANES-1]}}, 32'hFFFFFFFF}) == e_data,
          tag, "wr_data", wr_data, e_data);
    end
  endtask

  task automatic set_op(input logic [3:0] o, input logic [31:0] c,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] i);
    op = o; cond_w = c; opa_w = a; opb_w = b; imm = i;
    dst = AW'($urandom);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    do_reset();                                       // R1

    // R3: scalar select, zero and nonzero condition
    set_op(4'd1, 32'd0, 32'hAAAA0001, 32'hBBBB0002, 0); step();
    set_op(4'd1, 32'h80000000, 32'hAAAA0001, 32'hBBBB0002, 0); step();
    // R4: vector select, alternating lane conditions
    for (int i = 0; i < LANES; i++) begin
      vcond[i*32 +: 32] = (i % 2 == 0) ? 32'd0 : 32'd7;
      va[i*32 +: 32] = 32'h1000 + i;
      vb[i*32 +: 32] = 32'h2000 + i;
    end
    set_op(4'd2, 0, 0, 0, 0); step();
    // R5: wrap of the sum
    set_op(4'd3, 0, 32'hFFFFFFFF, 0, 32'd2); step();
    // R12: unused code
    set_op(4'd12, 32'd1, 32'd5, 32'd6, 32'd3); step();
    // R6: absolute jump, conditional not taken then taken
    set_op(4'd4, 0, 0, 0, 32'd20); step();
    set_op(4'd5, 32'd0, 0, 0, 32'd2); step();
    set_op(4'd5, 32'd9, 0, 0, 32'd2); step();
    // R7: negative relative offset from PC+1
    set_op(4'd6, 32'd1, 0, 0, 32'hFFFFFFFE); step();
    // R8: indirect
    set_op(4'd7, 0, 32'h0000_0011, 0, 0); step();
    // R10: pause disabled has no effect, enabled pauses
    pause_en = 1'b0; set_op(4'd9, 0, 0, 0, 0); step();
    pause_en = 1'b1; set_op(4'd9, 0, 0, 0, 0); step();
    set_op(4'd1, 32'd1, 32'd3, 32'd4, 0); step();     // ignored while paused
    run_cmd = 1'b1; set_op(4'd0, 0, 0, 0, 0); step();
    run_cmd = 1'b0; pause_en = 1'b0;
    // R11: end of program
    set_op(4'd4, 0, 0, 0, 32'd39); step();
    set_op(4'd0, 0, 0, 0, 0); step();
    set_op(4'd3, 0, 32'd1, 0, 32'd1); step();          // R11 no write at end
    set_op(4'd1, 32'd1, 32'd1, 32'd2, 0); step();      // R9 stopped stays
    do_reset();
    // R9: halt, then ignored ops
    set_op(4'd8, 0, 0, 0, 0); step();
    set_op(4'd4, 0, 0, 0, 32'd5); step();
    run_cmd = 1'b1; set_op(4'd3, 0, 32'd1, 0, 32'd1); step();
    run_cmd = 1'b0;
    do_reset();

    // random phase
    for (int n = 0; n < 600; n++) begin
      if (m_st == 2'd2) do_reset();
      pause_en = $urandom_range(1, 0);
      run_cmd  = ($urandom_range(3, 0) == 0);
      for (int i = 0; i < LANES; i++) begin
        vcond[i*32 +: 32] = rnd_word();
        va[i*32 +: 32] = $urandom;
        vb[i*32 +: 32] = $urandom;
      end
      begin
        logic [3:0]  o;
        logic [31:0] iv;
        logic [31:0] av;
        o  = 4'($urandom_range(11, 0));
        iv = $urandom;
        av = $urandom;
        if (o == 4'd4 || o == 4'd5) iv = $urandom_range(45, 0);
        if (o == 4'd6) iv = 32'($signed($urandom_range(16, 0)) - 8);
        if (o == 4'd7) av = $urandom_range(45, 0);
        if (o == 4'd8 && $urandom_range(3, 0) != 0) o = 4'd0;
        set_op(o, rnd_word(), av, $urandom, iv);
      end
      step();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule